// File: doc/BRIEF.md
# Line-21 Closed Caption Waveform Encoder

This block produces the caption data waveform for one chosen vertical-blanking line in each field. Upstream timing logic supplies the current line number, the current sample position within the line and a field flag. Software deposits two caption characters per field through a small register write port. On the chosen line, starting at a fixed sample, the block drives a per-sample level code into the video mixer. The line carries a clock run-in, a three-bit start pattern and then both characters. Each character is seven data bits, sent least significant first, followed by an odd parity bit. On every other sample the block asks the mixer to keep the normal video.

Bits are timed as a fraction of the line length. A phase accumulator adds the bit count per line, 32, on every sample, modulo the number of samples in a line. Each wrap of the accumulator opens the next bit slot. The bit rate is therefore locked to 32 times the line frequency, at both 50 Hz and 60 Hz field rates. Characters go into staging registers. A window takes a snapshot of its field's pair at the moment it opens, so a write made while a window is running is used from the next window onwards.

Top module: `cc_line21_enc`

## Requirements
- R1: While `rst` is high and after it, until a window opens, `out_pass` is 1 and `out_hi` is 0. All staging registers reset to zero.
- R2: A window opens only when `line_idx` equals 21 + `line_sel` (`line_sel` ranges 0..7) and `sample_idx` equals START_SAMPLE (default 280). `out_pass` falls in the cycle after that sample is presented.
- R3: The phase accumulator adds 32 per sample modulo LINE_SAMPLES (default 1716) and is cleared when a window opens. Each wrap starts a new bit slot. After 26 slots (0..25) the window closes and `out_pass` returns to 1.
- R4: Run-in, slots 0..6: `out_hi` is 1 while the accumulator is below LINE_SAMPLES/2 and 0 otherwise, giving seven full clock cycles.
- R5: Start pattern, slots 7, 8, 9: levels 0, 0, 1.
- R6: Data, slots 10..25. Slots 10..16 carry bits 0..6 of the first character, slot 17 its odd parity bit (set when bits 0..6 hold an even number of ones), and slots 18..25 do the same for the second character.
- R7: Bit 7 of a written character has no effect on the waveform.
- R8: `wr_addr` encodes {field, character}: address 0 and 1 are the first and second character of field 0, and address 2 and 3 those of field 1. The pair sent in a window is the one selected by `field_sel` at the opening sample.
- R9: `out_hi` = 1 requests the about 50 IRE level and 0 requests the 0 IRE level. Outside a window `out_hi` is 0.
- R10: A write in the opening cycle of a window, or while the window runs, does not alter that window. It is used by the next window of that field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| line_idx | input | LINE_W (10) | Current line number from the timing generator |
| sample_idx | input | SAMPLE_W (11) | Current sample within the line |
| field_sel | input | 1 | Field flag, selects the character pair |
| line_sel | input | SEL_W (3) | Offset added to line 21 to pick the target line |
| wr_en | input | 1 | Character write strobe |
| wr_addr | input | 2 | {field, character} of the write |
| wr_data | input | 8 | Character value; bit 7 ignored |
| out_pass | output | 1 | 1 = keep normal video on this sample |
| out_hi | output | 1 | Level code: 1 = about 50 IRE, 0 = 0 IRE |

## Verification
Two functions can meet in one cycle: a character write and the snapshot taken as a window opens. The bench provokes this by writing the first character of field 0 on the exact opening sample of a window, and also by writing during a running window. Its behavioural model takes the snapshot before applying the write, so any leak of the new value into the current window shows up as a per-cycle level mismatch and as a wrong count of high samples. The following window of that field is then checked to carry the new value.

// File: rtl/cc_pkg.sv
package cc_pkg;

    localparam int RUNIN_SLOTS = 7;
    localparam int FRAME_SLOTS = 3;
    localparam int CHAR_SLOTS  = 8;
    localparam int DATA_SLOTS  = 2 * CHAR_SLOTS;
    localparam int TOTAL_SLOTS = RUNIN_SLOTS + FRAME_SLOTS + DATA_SLOTS;
    localparam int SLOT_W      = $clog2(TOTAL_SLOTS);
    localparam int FIELDS      = 2;

    // start pattern levels, index 0 is sent first
    localparam logic [FRAME_SLOTS-1:0] FRAME_PAT = 3'b100;

    typedef logic [SLOT_W-1:0] slot_t;

    localparam slot_t FRAME_FIRST = slot_t'(RUNIN_SLOTS);
    localparam slot_t DATA_FIRST  = slot_t'(RUNIN_SLOTS + FRAME_SLOTS);
    localparam slot_t SECOND_FIRST = slot_t'(RUNIN_SLOTS + FRAME_SLOTS + CHAR_SLOTS);
    localparam slot_t SLOT_LAST   = slot_t'(TOTAL_SLOTS - 1);

    typedef enum logic [1:0] {
        SEG_RUNIN,
        SEG_FRAME,
        SEG_DATA
    } seg_e;

    typedef struct packed {
        logic [6:0] second;
        logic [6:0] first;
    } cc_pair_t;

    function automatic logic odd_fill(input logic [6:0] d);
        return ~(^d);
    endfunction

    function automatic seg_e seg_of(input slot_t s);
        if (s < FRAME_FIRST)
            return SEG_RUNIN;
        else if (s < DATA_FIRST)
            return SEG_FRAME;
        else
            return SEG_DATA;
    endfunction

endpackage

// File: rtl/cc_byte_regs.sv
module cc_byte_regs
    import cc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [1:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic       snap_en,
    input  logic       snap_fld,
    output cc_pair_t   snap_q
);

    cc_pair_t stage_w [FIELDS];

    logic unused_msb;
    assign unused_msb = wr_data[7];

    generate
        for (genvar f = 0; f < FIELDS; f++) begin : g_fld
            cc_pair_t st_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    st_q <= '0;
                end else if (wr_en && (wr_addr[1] == 1'(f))) begin
                    if (wr_addr[0])
                        st_q.second <= wr_data[6:0];
                    else
                        st_q.first <= wr_data[6:0];
                end
            end
            assign stage_w[f] = st_q;
        end
    endgenerate

    // snapshot reads the staged value from before any same-cycle write
    always_ff @(posedge clk) begin
        if (rst)
            snap_q <= '0;
        else if (snap_en)
            snap_q <= stage_w[snap_fld];
    end

endmodule

// File: rtl/cc_bit_timer.sv
module cc_bit_timer
    import cc_pkg::*;
#(
    parameter int LINE_SAMPLES  = 1716,
    parameter int BITS_PER_LINE = 32,
    parameter int ACC_W         = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output logic             active_q,
    output slot_t            slot_q,
    output logic [ACC_W-1:0] acc_q
);

    localparam logic [ACC_W:0] LEN  = (ACC_W+1)'(LINE_SAMPLES);
    localparam logic [ACC_W:0] STEP = (ACC_W+1)'(BITS_PER_LINE);

    logic [ACC_W:0] sum;
    logic           wrap;

    assign sum  = {1'b0, acc_q} + STEP;
    assign wrap = (sum >= LEN);

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            slot_q   <= '0;
            acc_q    <= '0;
        end else if (start) begin
            active_q <= 1'b1;
            slot_q   <= '0;
            acc_q    <= '0;
        end else if (active_q) begin
            if (wrap) begin
                acc_q <= ACC_W'(sum - LEN);
                if (slot_q == SLOT_LAST)
                    active_q <= 1'b0;
                else
                    slot_q <= slot_q + 1'b1;
            end else begin
                acc_q <= ACC_W'(sum);
            end
        end
    end

endmodule

// File: rtl/cc_wave_gen.sv
module cc_wave_gen
    import cc_pkg::*;
#(
    parameter int LINE_SAMPLES = 1716,
    parameter int ACC_W        = 11
) (
    input  logic             active,
    input  slot_t            slot,
    input  logic [ACC_W-1:0] acc,
    input  cc_pair_t         pair,
    output logic             out_pass,
    output logic             out_hi
);

    localparam logic [ACC_W-1:0] HALF = ACC_W'(LINE_SAMPLES / 2);

    logic [6:0] chr;
    logic [2:0] bit_idx;
    logic [1:0] frm_idx;
    logic       lvl;

    always_comb begin
        chr     = (slot >= SECOND_FIRST) ? pair.second : pair.first;
        bit_idx = 3'(slot - DATA_FIRST);
        frm_idx = 2'(slot - FRAME_FIRST);
        unique case (seg_of(slot))
            SEG_RUNIN: lvl = (acc < HALF);
            SEG_FRAME: lvl = FRAME_PAT[frm_idx];
            default:   lvl = (bit_idx == 3'd7) ? odd_fill(chr) : chr[bit_idx];
        endcase
        out_pass = ~active;
        out_hi   = active & lvl;
    end

endmodule

// File: rtl/cc_line21_enc.sv
module cc_line21_enc
    import cc_pkg::*;
#(
    parameter int LINE_W        = 10,
    parameter int SAMPLE_W      = 11,
    parameter int SEL_W         = 3,
    parameter int BASE_LINE     = 21,
    parameter int START_SAMPLE  = 280,
    parameter int LINE_SAMPLES  = 1716,
    parameter int BITS_PER_LINE = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [LINE_W-1:0]   line_idx,
    input  logic [SAMPLE_W-1:0] sample_idx,
    input  logic                field_sel,
    input  logic [SEL_W-1:0]    line_sel,
    input  logic                wr_en,
    input  logic [1:0]          wr_addr,
    input  logic [7:0]          wr_data,
    output logic                out_pass,
    output logic                out_hi
);

    localparam int ACC_W = $clog2(LINE_SAMPLES);

    logic [LINE_W-1:0] tgt_line;
    logic              start_w;
    logic              active_w;
    slot_t             slot_w;
    logic [ACC_W-1:0]  acc_w;
    cc_pair_t          pair_w;

    assign tgt_line = LINE_W'(BASE_LINE) + LINE_W'(line_sel);
    assign start_w  = (line_idx == tgt_line) &&
                      (sample_idx == SAMPLE_W'(START_SAMPLE));

    cc_byte_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .snap_en  (start_w),
        .snap_fld (field_sel),
        .snap_q   (pair_w)
    );

    cc_bit_timer #(
        .LINE_SAMPLES  (LINE_SAMPLES),
        .BITS_PER_LINE (BITS_PER_LINE),
        .ACC_W         (ACC_W)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .start    (start_w),
        .active_q (active_w),
        .slot_q   (slot_w),
        .acc_q    (acc_w)
    );

    cc_wave_gen #(
        .LINE_SAMPLES (LINE_SAMPLES),
        .ACC_W        (ACC_W)
    ) u_wave (
        .active   (active_w),
        .slot     (slot_w),
        .acc      (acc_w),
        .pair     (pair_w),
        .out_pass (out_pass),
        .out_hi   (out_hi)
    );

endmodule

// File: rtl/cc_line21_chk.sv
module cc_line21_chk
    import cc_pkg::*;
#(
    parameter int LINE_W        = 10,
    parameter int SAMPLE_W      = 11,
    parameter int SEL_W         = 3,
    parameter int BASE_LINE     = 21,
    parameter int START_SAMPLE  = 280,
    parameter int LINE_SAMPLES  = 1716,
    parameter int BITS_PER_LINE = 32,
    parameter int ACC_W         = 11
) (
    input logic                clk,
    input logic                rst,
    input logic [LINE_W-1:0]   line_idx,
    input logic [SAMPLE_W-1:0] sample_idx,
    input logic [SEL_W-1:0]    line_sel,
    input logic                out_pass,
    input logic                out_hi,
    input logic                active,
    input slot_t               slot,
    input logic [ACC_W-1:0]    acc
);

    logic open_now;
    logic last_wrap;

    assign open_now  = (line_idx == LINE_W'(BASE_LINE) + LINE_W'(line_sel)) &&
                       (sample_idx == SAMPLE_W'(START_SAMPLE));
    assign last_wrap = active && (slot == SLOT_LAST) &&
                       (({1'b0, acc} + (ACC_W+1)'(BITS_PER_LINE)) >= (ACC_W+1)'(LINE_SAMPLES));

    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (out_pass && !out_hi)); // R1

    AST_OPEN_ON_TARGET: assert property (@(posedge clk) disable iff (rst)
        open_now |=> (!out_pass && out_hi)); // R2

    AST_ACC_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        active |-> (acc < ACC_W'(LINE_SAMPLES))); // R3

    AST_SLOT_STEP: assert property (@(posedge clk) disable iff (rst)
        (active && $past(active) && !$past(open_now)) |->
        ((slot == $past(slot)) || (slot == slot_t'($past(slot) + 1'b1)))); // R3

    AST_CLOSE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        (last_wrap && !open_now) |=> out_pass); // R3

    AST_RUNIN_PEAK: assert property (@(posedge clk) disable iff (rst)
        (active && (slot < FRAME_FIRST) && (acc == '0)) |-> out_hi); // R4

    AST_FRAME_LOW: assert property (@(posedge clk) disable iff (rst)
        (active && (slot == FRAME_FIRST)) |-> !out_hi); // R5

    AST_PASS_QUIET: assert property (@(posedge clk) disable iff (rst)
        out_pass |-> !out_hi); // R9

endmodule

bind cc_line21_enc cc_line21_chk #(
    .LINE_W        (LINE_W),
    .SAMPLE_W      (SAMPLE_W),
    .SEL_W         (SEL_W),
    .BASE_LINE     (BASE_LINE),
    .START_SAMPLE  (START_SAMPLE),
    .LINE_SAMPLES  (LINE_SAMPLES),
    .BITS_PER_LINE (BITS_PER_LINE),
    .ACC_W         (ACC_W)
) chk_i (
    .clk        (clk),
    .rst        (rst),
    .line_idx   (line_idx),
    .sample_idx (sample_idx),
    .line_sel   (line_sel),
    .out_pass   (out_pass),
    .out_hi     (out_hi),
    .active     (active_w),
    .slot       (slot_w),
    .acc        (acc_w)
);

// File: tb/cc_line21_enc_tb_top.sv
module cc_line21_enc_tb_top;

    localparam int LS    = 1716;
    localparam int START = 280;
    localparam int BASE  = 21;

    logic        clk = 1'b0;
    logic        rst;
    logic [9:0]  line_idx;
    logic [10:0] sample_idx;
    logic        field_sel;
    logic [2:0]  line_sel;
    logic        wr_en;
    logic [1:0]  wr_addr;
    logic [7:0]  wr_data;
    logic        out_pass;
    logic        out_hi;

    always #4 clk = ~clk;

    cc_line21_enc dut_i (
        .clk        (clk),
        .rst        (rst),
        .line_idx   (line_idx),
        .sample_idx (sample_idx),
        .field_sel  (field_sel),
        .line_sel   (line_sel),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .out_pass   (out_pass),
        .out_hi     (out_hi)
    );

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // behavioural reference state
    int m_act = 0, m_acc = 0, m_slot = 0;
    int m_st[4] = '{0, 0, 0, 0};
    int m_c0 = 0, m_c1 = 0;
    int m_win = 0, m_hi = 0, d_win = 0, d_hi = 0, open_line = -1;

    task automatic chk(string tag, string what, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic int exp_level();
        int d, c, ones;
        if (m_act == 0) return 0;
        if (m_slot < 7) return (m_acc < LS / 2) ? 1 : 0;
        if (m_slot < 10) return (m_slot == 9) ? 1 : 0;
        d = m_slot - 10;
        c = (d < 8) ? m_c0 : m_c1;
        if ((d % 8) < 7) return (c >> (d % 8)) & 1;
        ones = 0;
        for (int k = 0; k < 7; k++) ones += (c >> k) & 1;
        return (ones % 2 == 0) ? 1 : 0;
    endfunction

    function automatic string level_tag();
        if (m_act == 0) return "R9";
        if (m_slot < 7) return "R4";
        if (m_slot < 10) return "R5";
        return "R6";
    endfunction

    // one sample: drive at negedge, model at posedge, compare at next negedge
    task automatic step(int ln, int smp, int fl, int sel, int we, int addr, int data);
        bit opened;
        line_idx   = 10'(ln);
        sample_idx = 11'(smp);
        field_sel  = 1'(fl);
        line_sel   = 3'(sel);
        wr_en      = 1'(we);
        wr_addr    = 2'(addr);
        wr_data    = 8'(data);
        @(posedge clk);
        opened = (ln == BASE + sel) && (smp == START);
        if (opened) begin
            m_c0 = m_st[fl * 2] & 127;
            m_c1 = m_st[fl * 2 + 1] & 127;
            m_act = 1; m_acc = 0; m_slot = 0;
        end else if (m_act != 0) begin
            m_acc += 32;
            if (m_acc >= LS) begin
                m_acc -= LS;
                if (m_slot == 25) m_act = 0;
                else m_slot++;
            end
        end
        if (we != 0) m_st[addr] = data;
        @(negedge clk);
        chk(opened ? "R2" : "R3", "out_pass", int'(out_pass), 1 - m_act);
        chk(level_tag(), "out_hi", int'(out_hi), exp_level());
        if (m_act != 0) m_win++;
        if (exp_level() != 0) m_hi++;
        if (!out_pass) begin
            d_win++;
            if (open_line < 0) open_line = ln;
        end
        if (out_hi) d_hi++;
    endtask

    task automatic sweep(int fl, int sel, int inj_l, int inj_s, int inj_a, int inj_d, string tag);
        m_win = 0; m_hi = 0; d_win = 0; d_hi = 0; open_line = -1;
        for (int ln = 20; ln < 30; ln++)
            for (int s = 0; s < LS; s++)
                step(ln, s, fl, sel, (ln == inj_l && s == inj_s) ? 1 : 0, inj_a, inj_d);
        chk(tag, "window length", d_win, m_win);
        chk(tag, "high samples", d_hi, m_hi);
        chk("R2", "opening line", open_line, BASE + sel);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        line_idx = '0; sample_idx = '0; field_sel = 1'b0; line_sel = '0;
        wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        @(negedge clk);
        repeat (3) @(negedge clk);
        // R1: idle levels while in reset
        chk("R1", "out_pass in reset", int'(out_pass), 1);
        chk("R1", "out_hi in reset", int'(out_hi), 0);
        rst = 1'b0;
        step(0, 0, 0, 0, 0, 0, 0);
        chk("R1", "out_pass after reset", int'(out_pass), 1);
        // load characters; address 2 carries bit 7 set (R7)
        step(0, 1, 0, 0, 1, 0, 'h41);
        step(0, 2, 0, 0, 1, 1, 'h2A);
        step(0, 3, 0, 0, 1, 2, 'hC5);
        step(0, 4, 0, 0, 1, 3, 'h7F);
        sweep(0, 0, -1, 0, 0, 0, "R6");
        // R7 and R8: field 1 pair, bit 7 of first character must be ignored
        sweep(1, 0, -1, 0, 0, 0, "R7");
        sweep(1, 5, -1, 0, 0, 0, "R8");
        // R10: write on the exact opening sample of line 28
        sweep(0, 7, 28, START, 0, 'h13, "R10");
        // R10: write inside the running window; 0x13 now in use
        sweep(0, 3, 24, 900, 1, 'h55, "R10");
        // run-in and new second character after a write outside the window
        sweep(0, 1, 25, 100, 3, 'h01, "R4");
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule